// File: doc/BRIEF.md
# Interlocked Three-Line Parallel Byte Port

This block is one byte-wide port on a shared instrument bus. In source role it takes a byte from a local valid/ready input. The byte comes with an end-of-message flag and a command flag. The block places all three on the bus and then paces a data-valid line against two lines from the acceptors: not-ready and not-accepted. In acceptor role it watches data-valid, drives its own not-ready and not-accepted lines, and passes each captured byte, with its flags, to a one-entry local output.

Every bus line is open-collector and wired-OR, so each line has a drive port and a sense port. A drive bit of 1 pulls the line low. Because the bus uses negative logic, a low line means logic 1. A transfer moves only when the slowest acceptor on the line allows it. A synchronous bus-clear input releases every line and returns both roles to idle.

Top module: `hs3_port`

## Requirements
- R1: The bus uses negative logic. A drive bit of 1 pulls its line low and means logic 1. A sensed level of 0 is read as logic 1. Bit 0 of the data drive and sense ports is data line 1, the least significant bit.
- R2: In source role, while idle, tx_ready is 1. On the cycle tx_valid and tx_ready are both 1, the byte, end flag and command flag are taken. From the next cycle they appear on dat_drv, last_drv and ctl_drv, and they stay there until the transfer completes.
- R3: The source raises vld_drv only after it senses not-ready released (nrdy_sns = 1). This happens no earlier than one cycle after the data is on the lines. While not-ready is sensed asserted, vld_drv stays 0.
- R4: While vld_drv is 1, the source waits for not-accepted to be sensed released (nacc_sns = 1). It drops vld_drv on the next cycle. It returns to idle, with tx_ready = 1 and the data lines released, one cycle after it senses not-accepted asserted again.
- R5: In acceptor role with an empty output, the block releases not-ready (nrdy_drv = 0) and holds not-accepted (nacc_drv = 1). When it senses data-valid asserted, it captures the data, end (last_sns = 0) and command (ctl_sns = 0) lines into rx_data, rx_end and rx_cmd. On the next cycle it raises rx_valid, releases not-accepted and asserts not-ready.
- R6: After the acceptor senses data-valid released, it asserts not-accepted again on the next cycle. It keeps not-ready asserted until the held byte has been taken through rx_ready.
- R7: While rx_valid is 1 and rx_ready is 0, rx_valid, rx_data, rx_end and rx_cmd hold their values.
- R8: Only the lines of the selected role are driven. With source_mode = 1, nrdy_drv and nacc_drv are 0. With source_mode = 0, vld_drv, dat_drv, last_drv and ctl_drv are 0. While active, the acceptor always asserts at least one of not-ready and not-accepted.
- R9: While bus_clr is 1, every drive output and tx_ready is 0. On the following cycle both roles are idle and the held received byte is discarded (rx_valid = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clr | input | 1 | Synchronous bus clear: release all lines, idle both roles |
| source_mode | input | 1 | 1 = source role, 0 = acceptor role |
| tx_valid | input | 1 | Local byte offered for sending |
| tx_ready | output | 1 | Source idle and able to take a byte |
| tx_data | input | DATA_W | Byte to send |
| tx_end | input | 1 | Byte is the last of a message |
| tx_cmd | input | 1 | Byte is an address/control byte |
| rx_valid | output | 1 | Captured byte held for the local side |
| rx_ready | input | 1 | Local side takes the held byte |
| rx_data | output | DATA_W | Captured byte |
| rx_end | output | 1 | Captured end-of-message flag |
| rx_cmd | output | 1 | Captured command flag |
| dat_drv | output | DATA_W | Data line pull-low enables |
| dat_sns | input | DATA_W | Data line levels |
| vld_drv | output | 1 | Data-valid pull-low enable |
| vld_sns | input | 1 | Data-valid line level |
| nrdy_drv | output | 1 | Not-ready pull-low enable |
| nrdy_sns | input | 1 | Not-ready line level |
| nacc_drv | output | 1 | Not-accepted pull-low enable |
| nacc_sns | input | 1 | Not-accepted line level |
| last_drv | output | 1 | End-of-message pull-low enable |
| last_sns | input | 1 | End-of-message line level |
| ctl_drv | output | 1 | Command-byte pull-low enable |
| ctl_sns | input | 1 | Command-byte line level |

## Verification
Every result is due a fixed number of clock edges after the line or handshake event that causes it. Data lines appear one edge after a tx handshake. Data-valid rises one edge after not-ready is sensed released, and falls one edge after not-accepted is sensed released. tx_ready returns one edge after not-accepted is sensed asserted again. On the acceptor side, rx_valid and the not-accepted/not-ready swap come one edge after data-valid is sensed, and not-accepted returns one edge after data-valid is released. The bench changes line levels and local inputs on the falling clock edge and samples one falling edge after each rising edge. It also holds lines in a stalling state for several cycles to confirm that nothing moves early.

// File: rtl/hs3_pkg.sv
// Package: state encodings shared by the source and acceptor sequencers.
package hs3_pkg;

    // Source sequencer states.
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,  // waiting for a local byte
        SRC_SETUP = 2'd1,  // data on lines, waiting for every acceptor ready
        SRC_VALID = 2'd2,  // data-valid asserted, waiting for all accepted
        SRC_CLOSE = 2'd3   // data-valid released, waiting for not-accepted again
    } src_state_t;

    // Acceptor sequencer states.
    typedef enum logic {
        ACC_WAIT = 1'b0,   // not-accepted held, waiting for data-valid
        ACC_DONE = 1'b1    // byte latched, waiting for data-valid to drop
    } acc_state_t;

endpackage

// File: rtl/hs3_source.sv
// Module: hs3_source
// Sends one byte per transfer over the interlocked three-line handshake.
// Assumes: sense inputs are synchronous to clk; drive outputs are pull-low
// enables (1 = line low = logic 1). en low holds the sequencer idle and
// releases all of its lines.
module hs3_source
    import hs3_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_end,
    input  logic              tx_cmd,
    input  logic              nrdy_sns,
    input  logic              nacc_sns,
    output logic [DATA_W-1:0] dat_drv,
    output logic              vld_drv,
    output logic              last_drv,
    output logic              ctl_drv
);

    src_state_t        state_q;
    logic [DATA_W-1:0] data_q;
    logic              end_q;
    logic              cmd_q;
    logic              busy;

    // Sequencer: idle -> setup -> valid -> close -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q <= SRC_IDLE;
        end else begin
            case (state_q)
                SRC_IDLE:  if (tx_valid) state_q <= SRC_SETUP;
                SRC_SETUP: if (nrdy_sns) state_q <= SRC_VALID;   // all ready
                SRC_VALID: if (nacc_sns) state_q <= SRC_CLOSE;   // all accepted
                SRC_CLOSE: if (!nacc_sns) state_q <= SRC_IDLE;   // re-armed
                default:   state_q <= SRC_IDLE;
            endcase
        end
    end

    // Byte register: loads on the local handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            end_q  <= 1'b0;
            cmd_q  <= 1'b0;
        end else if (tx_ready && tx_valid) begin
            data_q <= tx_data;
            end_q  <= tx_end;
            cmd_q  <= tx_cmd;
        end
    end

    // Line drive: data and flags for the whole transfer, data-valid in one state.
    always_comb begin
        busy     = en && (state_q != SRC_IDLE);
        tx_ready = en && (state_q == SRC_IDLE);
        dat_drv  = busy ? data_q : '0;
        last_drv = busy && end_q;
        ctl_drv  = busy && cmd_q;
        vld_drv  = en && (state_q == SRC_VALID);
    end

endmodule

// File: rtl/hs3_acceptor.sv
// Module: hs3_acceptor
// Takes bytes from the bus with the interlocked handshake into a one-entry
// local output. Assumes: sense inputs are synchronous to clk and low = logic 1.
// en low holds the sequencer idle and releases its lines; flush empties the
// held byte.
module hs3_acceptor
    import hs3_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              flush,
    input  logic [DATA_W-1:0] dat_sns,
    input  logic              vld_sns,
    input  logic              last_sns,
    input  logic              ctl_sns,
    output logic              nrdy_drv,
    output logic              nacc_drv,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_end,
    output logic              rx_cmd
);

    acc_state_t        state_q;
    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic              end_q;
    logic              cmd_q;
    logic              capture;

    // Capture when data-valid is sensed (low) and the output has room.
    always_comb begin
        capture = en && (state_q == ACC_WAIT) && !vld_sns && !full_q;
    end

    // Sequencer: wait for data-valid, then wait for its release.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q <= ACC_WAIT;
        end else if (capture) begin
            state_q <= ACC_DONE;
        end else if (state_q == ACC_DONE && vld_sns) begin
            state_q <= ACC_WAIT;
        end
    end

    // Output entry: fills on capture, empties on local take or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            full_q <= 1'b0;
        end else if (capture) begin
            full_q <= 1'b1;
        end else if (full_q && rx_ready) begin
            full_q <= 1'b0;
        end
    end

    // Byte register: inverts the negative-logic lines on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            end_q  <= 1'b0;
            cmd_q  <= 1'b0;
        end else if (capture) begin
            data_q <= ~dat_sns;
            end_q  <= ~last_sns;
            cmd_q  <= ~ctl_sns;
        end
    end

    // Line drive and local outputs.
    always_comb begin
        nacc_drv = en && (state_q == ACC_WAIT);
        nrdy_drv = en && ((state_q == ACC_DONE) || full_q);
        rx_valid = full_q;
        rx_data  = data_q;
        rx_end   = end_q;
        rx_cmd   = cmd_q;
    end

endmodule

// File: rtl/hs3_port.sv
// Module: hs3_port (top)
// One byte port on an open-collector, negative-logic instrument bus. It
// selects source or acceptor role and applies the synchronous bus clear.
// Assumes: sense inputs are already synchronous to clk.
module hs3_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clr,
    input  logic              source_mode,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_end,
    input  logic              tx_cmd,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_end,
    output logic              rx_cmd,
    output logic [DATA_W-1:0] dat_drv,
    input  logic [DATA_W-1:0] dat_sns,
    output logic              vld_drv,
    input  logic              vld_sns,
    output logic              nrdy_drv,
    input  logic              nrdy_sns,
    output logic              nacc_drv,
    input  logic              nacc_sns,
    output logic              last_drv,
    input  logic              last_sns,
    output logic              ctl_drv,
    input  logic              ctl_sns
);

    logic src_en;
    logic acc_en;

    // Role enables: the clear overrides both roles.
    always_comb begin
        src_en = source_mode && !bus_clr;
        acc_en = !source_mode && !bus_clr;
    end

    hs3_source #(.DATA_W(DATA_W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (src_en),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .tx_end   (tx_end),
        .tx_cmd   (tx_cmd),
        .nrdy_sns (nrdy_sns),
        .nacc_sns (nacc_sns),
        .dat_drv  (dat_drv),
        .vld_drv  (vld_drv),
        .last_drv (last_drv),
        .ctl_drv  (ctl_drv)
    );

    hs3_acceptor #(.DATA_W(DATA_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (acc_en),
        .flush    (bus_clr),
        .dat_sns  (dat_sns),
        .vld_sns  (vld_sns),
        .last_sns (last_sns),
        .ctl_sns  (ctl_sns),
        .nrdy_drv (nrdy_drv),
        .nacc_drv (nacc_drv),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .rx_data  (rx_data),
        .rx_end   (rx_end),
        .rx_cmd   (rx_cmd)
    );

endmodule

// File: rtl/hs3_port_chk.sv
// Module: hs3_port_chk
// Protocol checker for hs3_port, attached with bind below.
module hs3_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_clr,
    input logic              source_mode,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [DATA_W-1:0] rx_data,
    input logic [DATA_W-1:0] dat_drv,
    input logic              vld_drv,
    input logic              nrdy_drv,
    input logic              nacc_drv,
    input logic              last_drv,
    input logic              ctl_drv,
    input logic              nrdy_sns
);

    // R2
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_drv && $past(vld_drv)) |-> $stable(dat_drv));

    // R3
    valid_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vld_drv) |-> $past(nrdy_sns));

    // R7
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !bus_clr) |=> (rx_valid && $stable(rx_data)));

    // R8
    role_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((vld_drv || last_drv || ctl_drv || (|dat_drv)) && (nrdy_drv || nacc_drv)));

    // R8
    acc_interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!source_mode && !bus_clr) |-> (nrdy_drv || nacc_drv));

    // R9
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clr |-> !(vld_drv || nrdy_drv || nacc_drv || last_drv || ctl_drv
                      || tx_ready || (|dat_drv)));

endmodule

bind hs3_port hs3_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_clr     (bus_clr),
    .source_mode (source_mode),
    .tx_ready    (tx_ready),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .dat_drv     (dat_drv),
    .vld_drv     (vld_drv),
    .nrdy_drv    (nrdy_drv),
    .nacc_drv    (nacc_drv),
    .last_drv    (last_drv),
    .ctl_drv     (ctl_drv),
    .nrdy_sns    (nrdy_sns)
);

// File: tb/hs3_port_bench.sv
`timescale 1ns/1ps
// Directed bench for hs3_port: the bench plays the other bus parties.
module hs3_port_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_clr = 1'b0;
    logic         source_mode = 1'b0;
    logic         tx_valid = 1'b0;
    logic         tx_ready;
    logic [W-1:0] tx_data = '0;
    logic         tx_end = 1'b0;
    logic         tx_cmd = 1'b0;
    logic         rx_valid;
    logic         rx_ready = 1'b0;
    logic [W-1:0] rx_data;
    logic         rx_end, rx_cmd;
    logic [W-1:0] dat_drv, dat_sns;
    logic         vld_drv, vld_sns, nrdy_drv, nrdy_sns, nacc_drv, nacc_sns;
    logic         last_drv, last_sns, ctl_drv, ctl_sns;

    // Pull-low enables of the other parties on the bus.
    logic [W-1:0] ext_dat = '0;
    logic         ext_vld = 1'b0, ext_nrdy = 1'b0, ext_nacc = 1'b0;
    logic         ext_last = 1'b0, ext_ctl = 1'b0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    // Wired-OR open-collector lines: any pull makes the level low.
    assign dat_sns  = ~(dat_drv | ext_dat);
    assign vld_sns  = ~(vld_drv | ext_vld);
    assign nrdy_sns = ~(nrdy_drv | ext_nrdy);
    assign nacc_sns = ~(nacc_drv | ext_nacc);
    assign last_sns = ~(last_drv | ext_last);
    assign ctl_sns  = ~(ctl_drv | ext_ctl);

    hs3_port #(.DATA_W(W)) u_hs3_port (
        .clk(clk), .rst_n(rst_n), .bus_clr(bus_clr), .source_mode(source_mode),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_end(tx_end), .tx_cmd(tx_cmd),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_end(rx_end), .rx_cmd(rx_cmd),
        .dat_drv(dat_drv), .dat_sns(dat_sns), .vld_drv(vld_drv), .vld_sns(vld_sns),
        .nrdy_drv(nrdy_drv), .nrdy_sns(nrdy_sns), .nacc_drv(nacc_drv),
        .nacc_sns(nacc_sns), .last_drv(last_drv), .last_sns(last_sns),
        .ctl_drv(ctl_drv), .ctl_sns(ctl_sns)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset state in acceptor role.
    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R5 reset nacc_drv", nacc_drv, 1);
        check("R5 reset nrdy_drv", nrdy_drv, 0);
        check("R8 reset vld_drv", vld_drv, 0);
        check("R8 reset dat_drv", dat_drv, 0);
        check("R7 reset rx_valid", rx_valid, 0);
    endtask

    // Source transfer with slow acceptors holding each stage.
    task automatic t_source(input logic [7:0] b, input logic e, input logic c);
        source_mode = 1'b1;
        ext_nrdy = 1'b1;
        ext_nacc = 1'b1;
        step(1);
        check("R8 source role nrdy/nacc", {nrdy_drv, nacc_drv}, 0);
        check("R2 idle tx_ready", tx_ready, 1);
        tx_valid = 1'b1; tx_data = b; tx_end = e; tx_cmd = c;
        step(1);
        tx_valid = 1'b0;
        check("R1 R2 data lines", dat_drv, b);
        check("R2 end line", last_drv, e);
        check("R2 command line", ctl_drv, c);
        check("R2 tx_ready busy", tx_ready, 0);
        step(3);
        check("R3 valid held off by not-ready", vld_drv, 0);
        ext_nrdy = 1'b0;
        step(1);
        check("R3 valid after ready", vld_drv, 1);
        check("R2 data during valid", dat_drv, b);
        step(3);
        check("R4 valid held until accepted", vld_drv, 1);
        ext_nacc = 1'b0;
        ext_nrdy = 1'b1;
        step(1);
        check("R4 valid released", vld_drv, 0);
        step(2);
        check("R4 no ready before not-accepted", tx_ready, 0);
        ext_nacc = 1'b1;
        step(1);
        check("R4 ready after not-accepted", tx_ready, 1);
        check("R4 lines released", dat_drv, 0);
    endtask

    // Acceptor transfer driven by a bench source.
    task automatic t_accept(input logic [7:0] b, input logic e, input logic c);
        source_mode = 1'b0;
        ext_nrdy = 1'b0;
        ext_nacc = 1'b0;
        ext_dat = b; ext_last = e; ext_ctl = c;
        step(1);
        check("R5 empty releases nrdy", nrdy_drv, 0);
        check("R5 empty holds nacc", nacc_drv, 1);
        check("R8 acceptor role vld", vld_drv, 0);
        ext_vld = 1'b1;
        step(1);
        check("R5 rx_valid", rx_valid, 1);
        check("R1 R5 rx_data", rx_data, b);
        check("R5 rx_end", rx_end, e);
        check("R5 rx_cmd", rx_cmd, c);
        check("R5 nacc released", nacc_drv, 0);
        check("R5 nrdy asserted", nrdy_drv, 1);
        ext_vld = 1'b0;
        ext_dat = '0; ext_last = 1'b0; ext_ctl = 1'b0;
        step(1);
        check("R6 nacc back", nacc_drv, 1);
        check("R6 nrdy while full", nrdy_drv, 1);
        step(2);
        check("R7 rx_valid held", rx_valid, 1);
        check("R7 rx_data held", rx_data, b);
        rx_ready = 1'b1;
        step(1);
        rx_ready = 1'b0;
        check("R6 rx taken", rx_valid, 0);
        check("R6 nrdy released after take", nrdy_drv, 0);
    endtask

    // Bus clear in the middle of a source transfer and with a held byte.
    task automatic t_clear();
        source_mode = 1'b1;
        ext_nrdy = 1'b1;
        ext_nacc = 1'b1;
        step(1);
        tx_valid = 1'b1; tx_data = 8'h5A; tx_end = 1'b1; tx_cmd = 1'b1;
        step(1);
        tx_valid = 1'b0;
        bus_clr = 1'b1;
        #1;
        check("R9 lines released in clear", {dat_drv, last_drv, ctl_drv, vld_drv}, 0);
        check("R9 tx_ready in clear", tx_ready, 0);
        step(1);
        bus_clr = 1'b0;
        step(1);
        check("R9 source idle after clear", tx_ready, 1);
        check("R9 data released after clear", dat_drv, 0);
        // Held received byte is discarded by the clear.
        source_mode = 1'b0;
        ext_nrdy = 1'b0; ext_nacc = 1'b0;
        ext_dat = 8'h01;
        step(1);
        ext_vld = 1'b1;
        step(1);
        ext_vld = 1'b0;
        check("R5 held before clear", rx_valid, 1);
        bus_clr = 1'b1;
        #1;
        check("R9 acceptor lines released", {nrdy_drv, nacc_drv}, 0);
        step(1);
        bus_clr = 1'b0;
        check("R9 rx discarded", rx_valid, 0);
        step(1);
        check("R9 acceptor idle after clear", {nrdy_drv, nacc_drv}, 2'b01);
        ext_dat = '0;
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(1);
        t_reset();
        t_source(8'hA5, 1'b1, 1'b0);
        t_source(8'h01, 1'b0, 1'b1);
        t_accept(8'h3C, 1'b0, 1'b1);
        t_accept(8'h81, 1'b1, 1'b0);
        t_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule